// File: doc/BRIEF.md
# Serial Consumer-Control Bus Frame Receiver

This block listens to a single-wire, open-collector consumer-control bus and turns the pulse-width coded bit stream into whole frames. The line is sampled on a strobe that marks one timing unit (1 µs at the default parameters). A frame opens with a long start pulse. Each byte that follows is ten bit slots: eight data bits sent most significant first, one end-of-frame flag and one acknowledge slot. The receiver measures every low pulse and every bit period against limits set by parameters. It stores up to `MAX_BYTES` bytes and reports a finished frame with a one-cycle valid strobe. The length and the stored bytes accompany that strobe.

The receiver also takes part in the bus. When the low nibble of the first byte names a logical address whose bit is set in `addr_mask`, the receiver holds the line low through each acknowledge slot. Address 15 is the group (broadcast) address, and the receiver never drives its slots. When a falling edge arrives too early after the previous one, the receiver pulls the line low for an error hold time, so that the other nodes see that the bit period was broken. It then waits for the next start pulse. The output `drive_low` is meant to control an open-drain pull-down on the shared line.

Control is one state machine. In `ST_IDLE` a falling edge enters `ST_START_LOW`. A rise before `START_LOW_MIN` returns to idle; a later rise enters `ST_START_HIGH`. In `ST_START_HIGH` a falling edge clears the buffer and enters `ST_BIT_SAMPLE`. If the pulse exceeds `START_MAX` instead, the machine returns to idle. `ST_BIT_SAMPLE` samples the line at `SAMPLE_AT` and moves to `ST_BIT_WAIT`. In `ST_BIT_WAIT` an early edge goes to `ST_ERR_DRIVE` and a missing edge goes back to idle. An edge in time goes to `ST_BIT_SAMPLE`. When the acknowledge slot is due, the same edge goes to `ST_ACK_DRIVE` if this node must acknowledge, and to `ST_ACK_CHECK` otherwise. `ST_ACK_DRIVE` releases the line after `ACK_HOLD` and moves to `ST_ACK_CHECK`. At `RELEASE_BY`, `ST_ACK_CHECK` delivers the frame and goes idle if the flag was set and the line is high. Otherwise it returns to `ST_BIT_WAIT`. `ST_ERR_DRIVE` goes idle after `ERR_HOLD`.

Top module: `cec_frame_rx`

## Requirements
- R1: A start pulse is accepted only if its low part lasts at least START_LOW_MIN units and the next falling edge comes no later than START_MAX units after the pulse began. A rejected start pulse returns the receiver to idle, and no frame is reported.
- R2: Each data bit is sampled SAMPLE_AT units after its falling edge. A high level reads as 1 and a low level as 0. Bits arrive most significant first. Byte k of a frame appears at `msg_data[8k+7:8k]`, and unused bytes read as zero.
- R3: Slot 8 of each byte is the end-of-frame flag (1 = last byte). When it is sampled, the length becomes the byte index plus one. If the flag was 1 and the line is high RELEASE_BY units into that byte's acknowledge slot, `msg_valid` is high for exactly one cycle, with `msg_len` and `msg_data` valid in that cycle.
- R4: If the destination (bits 3:0 of byte 0) is not 15 and its bit in `addr_mask` is set, `drive_low` is high for about ACK_HOLD units starting at the falling edge of every acknowledge slot of the frame.
- R5: Frames to destination 15, and frames whose destination bit in `addr_mask` is clear, are not acknowledged. This applies when the mask is zero and when mask bit 15 is set. Such frames are still received and reported.
- R6: A falling edge that comes less than PERIOD_MIN units after the previous bit's falling edge makes the receiver hold `drive_low` high for ERR_HOLD units. No frame is reported, and the receiver then accepts a new frame.
- R7: If no falling edge comes within PERIOD_MAX units of the previous bit's falling edge, the partial frame is discarded without a report and the receiver returns to idle. Edges at any period between PERIOD_MIN and PERIOD_MAX are accepted.
- R8: Bytes past MAX_BYTES are dropped. `msg_len` saturates at MAX_BYTES, and the bytes already stored are kept unchanged.
- R9: After reset `drive_low` and `msg_valid` are low and `msg_len` and `msg_data` are zero. The line input passes through a two-flop synchroniser before any edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe per timing unit |
| line_in | input | 1 | Bus line level, asynchronous |
| addr_mask | input | 16 | One bit per logical address this node answers |
| drive_low | output | 1 | High to pull the bus line low |
| msg_valid | output | 1 | One-cycle strobe: a frame is complete |
| msg_len | output | $clog2(MAX_BYTES+1) | Number of bytes stored |
| msg_data | output | 8*MAX_BYTES | Stored bytes, byte 0 in the low bits |

## Verification
The bench runs the receiver at timings scaled down fifty times, with a four-byte buffer. A transmitter model shares a wired-AND line with the receiver. The bench sends two-byte frames to all sixteen destinations under a mask with bits 5, 9 and 15 set. This separates acknowledged frames, unaddressed frames and broadcast frames, both in the slot level seen by the transmitter and in the drive time. Frames of one to six bytes separate normal length counting from the saturation and dropping past the buffer. Start pulses that are too short or too long, bit periods near both limits, an early edge and a stalled frame separate the rejection paths from each other and from the error hold. Each faulty frame is followed by a clean frame to confirm that the receiver recovers.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LOW,
        ST_START_HIGH,
        ST_BIT_SAMPLE,
        ST_BIT_WAIT,
        ST_ACK_DRIVE,
        ST_ACK_CHECK,
        ST_ERR_DRIVE
    } rx_state_e;

    localparam logic [3:0] GROUP_ADDR = 4'hF;

endpackage

// File: rtl/cec_rx_sync.sv
// Two-flop synchroniser with falling-edge detection on the synchronised level.
module cec_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_s,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    // Idle bus level is high, so reset to 1 to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fall   = prev_q & ~sync_q;
endmodule

// File: rtl/cec_rx_timer.sv
// Saturating unit counter; clear has priority over counting.
module cec_rx_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cec_rx_buffer.sv
// Collects sampled bits into bytes, tracks the slot position, the flag and the length.
module cec_rx_buffer #(
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   sample_en,
    input  logic                   sample_val,
    input  logic                   slot_done,
    output logic                   at_ack,
    output logic                   eom,
    output logic [$clog2(MAX_BYTES+1)-1:0] len,
    output logic [3:0]             dest,
    output logic [8*MAX_BYTES-1:0] data
);
    localparam int LEN_W = $clog2(MAX_BYTES + 1);

    logic [3:0]       bitpos_q;
    logic [LEN_W-1:0] byte_q;
    logic             in_range;
    logic [MAX_BYTES-1:0][7:0] mem_q;

    assign in_range = byte_q < LEN_W'(MAX_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitpos_q <= '0;
            byte_q   <= '0;
            eom      <= 1'b0;
            len      <= '0;
        end else if (clear) begin
            bitpos_q <= '0;
            byte_q   <= '0;
            eom      <= 1'b0;
            len      <= '0;
        end else if (sample_en) begin
            if (bitpos_q == 4'd8) begin
                eom <= sample_val;
                len <= in_range ? byte_q + 1'b1 : LEN_W'(MAX_BYTES);
            end
            bitpos_q <= bitpos_q + 1'b1;
        end else if (slot_done) begin
            bitpos_q <= '0;
            if (in_range) begin
                byte_q <= byte_q + 1'b1;
            end
        end
    end

    // One storage byte per slot; bytes past the end match no slot and are dropped.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (clear) begin
                mem_q[g] <= '0;
            end else if (sample_en && (bitpos_q < 4'd8) && (byte_q == LEN_W'(g))) begin
                mem_q[g][3'(4'd7 - bitpos_q)] <= sample_val;
            end
        end
    end

    assign at_ack = (bitpos_q == 4'd9);
    assign dest   = mem_q[0][3:0];
    assign data   = mem_q;
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
    import cec_rx_pkg::*;
#(
    parameter int START_LOW_MIN = 3500,
    parameter int START_MAX     = 4700,
    parameter int SAMPLE_AT     = 850,
    parameter int PERIOD_MIN    = 2050,
    parameter int PERIOD_MAX    = 2750,
    parameter int ACK_HOLD      = 1500,
    parameter int RELEASE_BY    = 1750,
    parameter int ERR_HOLD      = 3600,
    parameter int MAX_BYTES     = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick_us,
    input  logic                             line_in,
    input  logic [15:0]                      addr_mask,
    output logic                             drive_low,
    output logic                             msg_valid,
    output logic [$clog2(MAX_BYTES+1)-1:0]   msg_len,
    output logic [8*MAX_BYTES-1:0]           msg_data
);
    localparam int LIM_A   = (START_MAX > PERIOD_MAX) ? START_MAX : PERIOD_MAX;
    localparam int CNT_LIM = ((LIM_A > ERR_HOLD) ? LIM_A : ERR_HOLD) + 2;
    localparam int CNT_W   = $clog2(CNT_LIM + 1);

    rx_state_e        state_q, state_d;
    logic             line_s, fall_s;
    logic [CNT_W-1:0] count;
    logic             cnt_clr, buf_clr, smp_en, slot_done, deliver;
    logic             at_ack, eom, ack_me;
    logic [3:0]       dest;

    cec_rx_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_in),
        .line_s     (line_s),
        .fall       (fall_s)
    );

    cec_rx_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .clear (cnt_clr),
        .count (count)
    );

    cec_rx_buffer #(.MAX_BYTES(MAX_BYTES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (buf_clr),
        .sample_en  (smp_en),
        .sample_val (line_s),
        .slot_done  (slot_done),
        .at_ack     (at_ack),
        .eom        (eom),
        .len        (msg_len),
        .dest       (dest),
        .data       (msg_data)
    );

    assign ack_me = (dest != GROUP_ADDR) && addr_mask[dest];

    // Next-state and control strobes
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        buf_clr   = 1'b0;
        smp_en    = 1'b0;
        slot_done = 1'b0;
        deliver   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_s) begin
                    cnt_clr = 1'b1;
                    state_d = ST_START_LOW;
                end
            end
            ST_START_LOW: begin
                if (line_s) begin
                    state_d = (count < CNT_W'(START_LOW_MIN)) ? ST_IDLE : ST_START_HIGH;
                end else if (count > CNT_W'(START_MAX)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_START_HIGH: begin
                if (fall_s) begin
                    cnt_clr = 1'b1;
                    buf_clr = 1'b1;
                    state_d = ST_BIT_SAMPLE;
                end else if (count > CNT_W'(START_MAX)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BIT_SAMPLE: begin
                if (count >= CNT_W'(SAMPLE_AT)) begin
                    smp_en  = 1'b1;
                    state_d = ST_BIT_WAIT;
                end
            end
            ST_BIT_WAIT: begin
                if (fall_s) begin
                    cnt_clr = 1'b1;
                    if (count < CNT_W'(PERIOD_MIN)) begin
                        state_d = ST_ERR_DRIVE;
                    end else if (at_ack) begin
                        state_d = ack_me ? ST_ACK_DRIVE : ST_ACK_CHECK;
                    end else begin
                        state_d = ST_BIT_SAMPLE;
                    end
                end else if (count > CNT_W'(PERIOD_MAX)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ACK_DRIVE: begin
                if (count >= CNT_W'(ACK_HOLD)) begin
                    state_d = ST_ACK_CHECK;
                end
            end
            ST_ACK_CHECK: begin
                if (count >= CNT_W'(RELEASE_BY)) begin
                    if (line_s && eom) begin
                        deliver = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        slot_done = 1'b1;
                        state_d   = ST_BIT_WAIT;
                    end
                end
            end
            ST_ERR_DRIVE: begin
                if (count >= CNT_W'(ERR_HOLD)) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_low <= 1'b0;
            msg_valid <= 1'b0;
        end else begin
            drive_low <= (state_d == ST_ACK_DRIVE) || (state_d == ST_ERR_DRIVE);
            msg_valid <= deliver;
        end
    end
endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk
    import cec_rx_pkg::*;
#(
    parameter int MAX_BYTES = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           drive_low,
    input logic                           msg_valid,
    input logic [$clog2(MAX_BYTES+1)-1:0] msg_len,
    input logic                           line_s,
    input logic                           fall_s,
    input rx_state_e                      state_q,
    input logic [3:0]                     dest,
    input logic [15:0]                    addr_mask
);
    // R3: the valid strobe lasts a single cycle
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    // R3: delivery only after the line was seen high
    p_valid_line_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(line_s));

    // R8: reported length stays within the buffer
    p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_len != '0) && (msg_len <= ($clog2(MAX_BYTES+1))'(MAX_BYTES)));

    // R6: the receiver only starts pulling low right after a falling edge
    p_drive_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> $past(fall_s));

    // R4: acknowledge drive only for a masked, non-group destination
    p_ack_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DRIVE) |-> ((dest != GROUP_ADDR) && addr_mask[dest]));

    // R9: no drive while resting in idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && ($past(state_q) == ST_IDLE)) |-> !drive_low);
endmodule

bind cec_frame_rx cec_frame_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_low (drive_low),
    .msg_valid (msg_valid),
    .msg_len   (msg_len),
    .line_s    (line_s),
    .fall_s    (fall_s),
    .state_q   (state_q),
    .dest      (dest),
    .addr_mask (addr_mask)
);

// File: tb/cec_frame_rx_test.sv
module cec_frame_rx_test;
    localparam int MAXB     = 4;
    localparam int ACK_T    = 30;
    localparam int ERR_T    = 72;
    localparam int LEN_W    = $clog2(MAXB + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_line = 1'b1;
    logic [15:0]       mask = 16'h0;
    logic              drive_low, msg_valid;
    logic [LEN_W-1:0]  msg_len;
    logic [8*MAXB-1:0] msg_data;
    wire               line_w = tx_line & ~drive_low;

    int checks = 0, fails = 0, vcount = 0, drv_total = 0;
    logic [LEN_W-1:0]  cap_len;
    logic [8*MAXB-1:0] cap_data;
    logic [7:0]        fb [0:7];
    logic              ackd [0:7];
    bit                done = 1'b0;

    always #10 clk = ~clk;

    cec_frame_rx #(
        .START_LOW_MIN(70), .START_MAX(94), .SAMPLE_AT(17),
        .PERIOD_MIN(41), .PERIOD_MAX(55), .ACK_HOLD(ACK_T),
        .RELEASE_BY(35), .ERR_HOLD(ERR_T), .MAX_BYTES(MAXB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(1'b1), .line_in(line_w),
        .addr_mask(mask), .drive_low(drive_low), .msg_valid(msg_valid),
        .msg_len(msg_len), .msg_data(msg_data)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            vcount++;
            cap_len  = msg_len;
            cap_data = msg_data;
        end
        if (rst_n && drive_low) drv_total++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_ack(input logic [3:0] d, input logic [15:0] m);
        return (d != 4'hF) && m[d];
    endfunction

    task automatic tx_start(input int low, input int total);
        tx_line = 1'b0;
        for (int c = 0; c < total; c++) begin
            if (c == low) tx_line = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic tx_bit(input logic v, input int total, output logic smp);
        int low = v ? 12 : 30;
        smp = 1'b1;
        tx_line = 1'b0;
        for (int c = 0; c < total; c++) begin
            if (c == low) tx_line = 1'b1;
            if (c == 20) smp = line_w;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int n, input int slow, input int stot, input int per);
        logic s;
        tx_start(slow, stot);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) tx_bit(fb[i][b], per, s);
            tx_bit(i == n - 1, per, s);
            tx_bit(1'b1, per, s);
            ackd[i] = !s;
        end
        tx_line = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    // Sends a clean two-byte frame and checks that it is delivered (recovery)
    task automatic good_frame(input string req);
        int v0 = vcount;
        fb[0] = 8'h3A; fb[1] = 8'hC6;
        send_frame(2, 74, 90, 48);
        chk(vcount == v0 + 1, req, "recovery frame delivered", vcount - v0, 1);
        chk(cap_data == {16'h0, 8'hC6, 8'h3A}, req, "recovery data", cap_data, {16'h0, 8'hC6, 8'h3A});
    endtask

    initial begin
        int v0, d0;
        logic s;
        logic [8*MAXB-1:0] expd;
        int elen;
        repeat (5) @(negedge clk);
        // R9: reset state
        chk(!drive_low && !msg_valid, "R9", "reset drive/valid", {drive_low, msg_valid}, 0);
        chk(msg_len == 0 && msg_data == 0, "R9", "reset len/data", msg_len, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 R3 R4 R5: every destination under mask with bits 5, 9, 15
        mask = 16'h8220;
        for (int d = 0; d < 16; d++) begin
            logic ea;
            fb[0] = {4'h4, 4'(d)};
            fb[1] = 8'(d * 37 + 11);
            ea = exp_ack(4'(d), mask);
            v0 = vcount; d0 = drv_total;
            send_frame(2, 74, 90, 48);
            chk(vcount == v0 + 1, "R3", "one valid per frame", vcount - v0, 1);
            chk(cap_len == 2, "R3", "length of two-byte frame", cap_len, 2);
            chk(cap_data == {16'h0, fb[1], fb[0]}, "R2", "frame bytes", cap_data, {16'h0, fb[1], fb[0]});
            for (int i = 0; i < 2; i++)
                chk(ackd[i] == ea, ea ? "R4" : "R5", "ack slot level", ackd[i], ea);
            if (ea)
                chk((drv_total - d0 >= 2 * ACK_T) && (drv_total - d0 <= 2 * (ACK_T + 3)),
                    "R4", "ack drive length", drv_total - d0, 2 * ACK_T);
            else
                chk(drv_total == d0, "R5", "no drive when not addressed", drv_total - d0, 0);
        end

        // R5: zero mask, still delivered, never acknowledged
        mask = 16'h0;
        fb[0] = 8'h45;
        v0 = vcount; d0 = drv_total;
        send_frame(1, 74, 90, 48);
        chk(vcount == v0 + 1 && cap_len == 1, "R5", "zero mask frame delivered", cap_len, 1);
        chk(!ackd[0] && drv_total == d0, "R5", "zero mask not acked", drv_total - d0, 0);

        // R8 R3: lengths 1..6 against a four-byte buffer
        for (int n = 1; n <= 6; n++) begin
            for (int i = 0; i < n; i++) fb[i] = 8'(n * 16 + i * 7 + 3);
            elen = (n < MAXB) ? n : MAXB;
            expd = '0;
            for (int i = 0; i < MAXB; i++) if (i < elen) expd[i*8 +: 8] = fb[i];
            v0 = vcount;
            send_frame(n, 74, 90, 48);
            chk(vcount == v0 + 1, "R3", "valid for length sweep", vcount - v0, 1);
            chk(cap_len == LEN_W'(elen), "R8", "length saturation", cap_len, elen);
            chk(cap_data == expd, "R8", "stored bytes kept", cap_data, expd);
        end

        // R1: start pulse limits
        mask = 16'h0020;
        fb[0] = 8'h05; fb[1] = 8'h99;
        v0 = vcount; d0 = drv_total;
        send_frame(2, 50, 90, 48);
        chk(vcount == v0 && drv_total == d0, "R1", "short start low rejected", vcount - v0, 0);
        v0 = vcount; d0 = drv_total;
        send_frame(2, 74, 100, 48);
        chk(vcount == v0 && drv_total == d0, "R1", "long start rejected", vcount - v0, 0);
        v0 = vcount;
        send_frame(2, 72, 92, 48);
        chk(vcount == v0 + 1 && cap_data == {16'h0, 8'h99, 8'h05}, "R1", "start near limits accepted", vcount - v0, 1);

        // R7: bit periods near both limits are accepted
        for (int k = 0; k < 2; k++) begin
            int per = (k == 0) ? 44 : 52;
            v0 = vcount;
            fb[0] = 8'(8'h50 + k); fb[1] = 8'(8'hA0 + k);
            send_frame(2, 74, 90, per);
            chk(vcount == v0 + 1 && cap_data == {16'h0, fb[1], fb[0]}, "R7", "period in range", per, 1);
        end

        // R6: early falling edge -> error hold
        v0 = vcount; d0 = drv_total;
        tx_start(74, 90);
        tx_bit(1'b1, 48, s);
        tx_bit(1'b0, 35, s);
        tx_line = 1'b0;
        repeat (12) @(negedge clk);
        tx_line = 1'b1;
        repeat (150) @(negedge clk);
        chk((drv_total - d0 >= ERR_T) && (drv_total - d0 <= ERR_T + 3), "R6", "error hold length", drv_total - d0, ERR_T);
        chk(vcount == v0, "R6", "no frame after error", vcount - v0, 0);
        good_frame("R6");

        // R7: stalled frame is dropped
        v0 = vcount; d0 = drv_total;
        tx_start(74, 90);
        for (int i = 0; i < 3; i++) tx_bit(1'b1, 48, s);
        tx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk(vcount == v0 && drv_total == d0, "R7", "stalled frame discarded", vcount - v0, 0);
        good_frame("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule